// File: doc/BRIEF.md
# Adaptive Dead-Time Half-Bridge Gate Sequencer

This block sits between a digital PWM command and the two gate drivers of a synchronous buck half-bridge. It produces two gate enables, `hs_on` for the high-side switch and `ls_on` for the low-side switch. The two enables are never active together.

The gap between one switch turning off and the other turning on is not a fixed count. Each turn-on waits for a comparator flag that reports the state of the opposite switch:

- `lgate_low` reports that the low-side gate has discharged. The high side waits for it.
- `phase_low` reports that the switch node has fallen. The low side waits for it.

If the switch node never falls, for instance while inductor current is negative, a timeout counter turns the low side on anyway. This lets the current recirculate.

A protection manager drives the `run` qualifier. While `run` is deasserted, the block parks in an idle state with both gates off. Both comparator flags are asynchronous and pass through a two-flop synchronizer inside the block.

Top module: `gate_deadtime_seq`

## Requirements
- R1: `hs_on` and `ls_on` are never 1 in the same cycle, in any state and under any input sequence.
- R2: When `pwm` is sampled 0 while the high side is on, `hs_on` is 0 from the next clock edge on. `ls_on` stays 0 until the synchronized `phase_low` is seen. With `phase_low` held at 1, `ls_on` becomes 1 after the third rising edge that samples it (two synchronizer stages plus the state register).
- R3: When `pwm` is sampled 1 while the low side is on, `ls_on` is 0 from the next clock edge on. `hs_on` stays 0 until the synchronized `lgate_low` is seen. It becomes 1 after the third rising edge that samples `lgate_low` at 1.
- R4: If `phase_low` stays 0 after the high side turns off, `ls_on` becomes 1 exactly `WD_CYCLES` clock cycles (default 32) after the edge at which `hs_on` dropped.
- R5: The timeout restarts from zero each time the sequencer enters the wait for the switch node to fall. Time spent in an earlier wait does not count.
- R6: While `run` is sampled 0, both enables are 0 from the next clock edge, whatever `pwm` does. When `run` returns to 1, the sequencer restarts through the wait state that matches the current `pwm` level.
- R7: A `pwm` change during a wait state changes the target switch. It never bypasses the comparator wait for the new target:
  - a rise while waiting for the switch node to fall leads to a wait for `lgate_low`;
  - a fall while waiting for `lgate_low` leads to a wait for `phase_low` with a fresh timeout.
- R8: After reset both enables are 0.
- R9: A comparator flag has no effect outside the wait state that uses it. For example, `phase_low` at 1 while the high side is on leaves `hs_on` at 1.
- R10: On every cycle, `hs_on` and `ls_on` equal a cycle-level model built from R2 to R9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Enable qualifier from protection; 0 forces both gates off |
| pwm | input | 1 | PWM command: 1 requests high side, 0 requests low side |
| phase_low | input | 1 | Asynchronous comparator flag: switch node has fallen |
| lgate_low | input | 1 | Asynchronous comparator flag: low-side gate has discharged |
| hs_on | output | 1 | High-side gate enable |
| ls_on | output | 1 | Low-side gate enable |

## Verification
The assertions take `run` and `pwm` to be synchronous to `clk`. They also assume that every turn-on decision is caused only by the synchronized comparator flags or by the timeout, and never by the raw asynchronous pins. The stimulus therefore changes all inputs on the falling clock edge, so each value is held for a full cycle before it is sampled. Comparator flags are set and cleared independently of the gate state. This covers both the realistic orderings and stale or early flags.

// File: rtl/gds_pkg.sv
package gds_pkg;

  typedef enum logic [4:0] {
    GS_IDLE   = 5'b00001,
    GS_HIGH   = 5'b00010,
    GS_WAIT_N = 5'b00100,
    GS_LOW    = 5'b01000,
    GS_WAIT_G = 5'b10000
  } gds_state_e;

  // Timeout reached once the count has advanced limit-1 times.
  function automatic logic tmo_reached(input logic [31:0] count,
                                       input logic [31:0] limit);
    return (count + 32'd1) >= limit;
  endfunction

endpackage

// File: rtl/gds_sync.sv
module gds_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stage;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage[0] <= '0;
    else        stage[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage[i] <= '0;
      else        stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/gds_timeout.sv
module gds_timeout
  import gds_pkg::*;
#(
  parameter int LIMIT = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] count;
  logic          reached;

  assign reached = tmo_reached(32'(count), 32'(LIMIT));
  assign expired = armed && reached;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count <= '0;
    else if (!armed)   count <= '0;
    else if (!reached) count <= count + 1'b1;
  end
endmodule

// File: rtl/gds_fsm.sv
module gds_fsm
  import gds_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       pwm,
  input  logic       node_fell,
  input  logic       gate_clear,
  input  logic       tmo_fire,
  output gds_state_e state,
  output logic       hs_en,
  output logic       ls_en
);
  gds_state_e nxt;

  always_comb begin
    nxt = state;
    if (!run) begin
      nxt = GS_IDLE;
    end else begin
      unique case (state)
        GS_IDLE:   nxt = pwm ? GS_WAIT_G : GS_WAIT_N;
        GS_HIGH:   if (!pwm) nxt = GS_WAIT_N;
        GS_WAIT_N: begin
          if (pwm)                        nxt = GS_WAIT_G;
          else if (node_fell || tmo_fire) nxt = GS_LOW;
        end
        GS_LOW:    if (pwm) nxt = GS_WAIT_G;
        GS_WAIT_G: begin
          if (!pwm)           nxt = GS_WAIT_N;
          else if (gate_clear) nxt = GS_HIGH;
        end
        default:   nxt = GS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= GS_IDLE;
    else        state <= nxt;
  end

  assign hs_en = (state == GS_HIGH);
  assign ls_en = (state == GS_LOW);
endmodule

// File: rtl/gate_deadtime_seq.sv
module gate_deadtime_seq
  import gds_pkg::*;
#(
  parameter int WD_CYCLES   = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic pwm,
  input  logic phase_low,
  input  logic lgate_low,
  output logic hs_on,
  output logic ls_on
);
  localparam int NFLAG = 2;

  logic [NFLAG-1:0] flag_raw, flag_sync;
  logic             node_fell, gate_clear, tmo_fire, wait_node;
  gds_state_e       state;

  assign flag_raw   = {lgate_low, phase_low};
  assign node_fell  = flag_sync[0];
  assign gate_clear = flag_sync[1];
  assign wait_node  = (state == GS_WAIT_N);

  gds_sync #(.W(NFLAG), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(flag_raw), .q(flag_sync)
  );

  gds_timeout #(.LIMIT(WD_CYCLES)) u_tmo (
    .clk(clk), .rst_n(rst_n), .armed(wait_node), .expired(tmo_fire)
  );

  gds_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .run(run), .pwm(pwm),
    .node_fell(node_fell), .gate_clear(gate_clear), .tmo_fire(tmo_fire),
    .state(state), .hs_en(hs_on), .ls_en(ls_on)
  );
endmodule

// File: rtl/gate_deadtime_seq_chk.sv
module gate_deadtime_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic run,
  input logic pwm,
  input logic hs_on,
  input logic ls_on,
  input logic node_fell,
  input logic gate_clear,
  input logic tmo_fire
);
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_on && ls_on));                                         // R1

  AST_HS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_on && !pwm) |=> !hs_on);                                // R2

  AST_LS_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_on) |-> $past(node_fell || tmo_fire));             // R4

  AST_LS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (ls_on && pwm) |=> !ls_on);                                 // R3

  AST_HS_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_on) |-> $past(gate_clear));                        // R7

  AST_RUN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!hs_on && !ls_on));                               // R6
endmodule

bind gate_deadtime_seq gate_deadtime_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .pwm(pwm),
  .hs_on(hs_on), .ls_on(ls_on),
  .node_fell(node_fell), .gate_clear(gate_clear), .tmo_fire(tmo_fire)
);

// File: tb/test_gate_deadtime_seq.sv
`timescale 1ns/1ps
module test_gate_deadtime_seq;
  localparam int WD = 32;
  localparam int ST_IDLE = 0, ST_HI = 1, ST_WN = 2, ST_LO = 3, ST_WG = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic run = 1'b0, pwm = 1'b0, phase_low = 1'b0, lgate_low = 1'b0;
  logic hs_on, ls_on;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gate_deadtime_seq #(.WD_CYCLES(WD)) i_gate_deadtime_seq (
    .clk(clk), .rst_n(rst_n), .run(run), .pwm(pwm),
    .phase_low(phase_low), .lgate_low(lgate_low),
    .hs_on(hs_on), .ls_on(ls_on)
  );

  // Behavioural reference model
  int m_st = ST_IDLE, m_wait = 0;
  bit phq[$] = '{1'b0, 1'b0};
  bit lgq[$] = '{1'b0, 1'b0};
  bit m_hs, m_ls;
  assign m_hs = (m_st == ST_HI);
  assign m_ls = (m_st == ST_LO);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = ST_IDLE; m_wait = 0;
      phq = '{1'b0, 1'b0}; lgq = '{1'b0, 1'b0};
    end else begin
      bit ph, lg;
      int nst;
      ph = phq.pop_front(); phq.push_back(phase_low);
      lg = lgq.pop_front(); lgq.push_back(lgate_low);
      nst = m_st;
      if (!run) nst = ST_IDLE;
      else if (m_st == ST_IDLE) nst = pwm ? ST_WG : ST_WN;
      else if (m_st == ST_HI && !pwm) nst = ST_WN;
      else if (m_st == ST_LO && pwm) nst = ST_WG;
      else if (m_st == ST_WN) begin
        if (pwm) nst = ST_WG;
        else if (ph || m_wait == WD - 1) nst = ST_LO;
      end else if (m_st == ST_WG) begin
        if (!pwm) nst = ST_WN;
        else if (lg) nst = ST_HI;
      end
      m_wait = (nst == ST_WN && m_st == ST_WN) ? m_wait + 1 : 0;
      m_st = nst;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_cmp++;
      if (hs_on !== m_hs || ls_on !== m_ls) begin
        n_bad++;
        $display("FAIL R10 model: hs/ls actual %b%b expected %b%b", hs_on, ls_on, m_hs, m_ls);
      end
      n_cmp++;
      if (hs_on && ls_on) begin
        n_bad++;
        $display("FAIL R1 overlap: actual hs=1 ls=1 expected not both");
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_up;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      finish_up();
    end
  end

  // Steps from a pwm drive until ls_on is seen high
  task automatic count_to_ls(output int k);
    k = 0;
    while (!ls_on && k < 500) begin step(1); k++; end
  endtask

  initial begin
    int k;
    step(3);
    chk(hs_on == 0 && ls_on == 0, "R8 reset", {hs_on, ls_on}, 0);
    rst_n = 1'b1;
    step(2);
    chk(hs_on == 0 && ls_on == 0, "R8 idle without run", {hs_on, ls_on}, 0);

    // Start high: lgate already low
    run = 1; pwm = 1; lgate_low = 1;
    step(6);
    chk(hs_on == 1, "R3 high side from start", hs_on, 1);

    // R9: phase flag while high side on has no effect
    phase_low = 1; step(5);
    chk(hs_on == 1 && ls_on == 0, "R9 phase flag ignored in high state", {hs_on, ls_on}, 2);
    phase_low = 0; step(3);

    // R2: falling pwm, phase comparator arrives later
    pwm = 0; lgate_low = 0; step(1);
    chk(hs_on == 0 && ls_on == 0, "R2 hs drops first", {hs_on, ls_on}, 0);
    step(4);
    phase_low = 1; step(2);
    chk(ls_on == 0, "R2 ls waits for sync", ls_on, 0);
    step(1);
    chk(ls_on == 1, "R2 ls on third edge", ls_on, 1);
    phase_low = 0; lgate_low = 1;
    step(3);

    // R9: lgate flag while low side on has no effect
    chk(ls_on == 1 && hs_on == 0, "R9 gate flag ignored in low state", {hs_on, ls_on}, 1);
    lgate_low = 0; step(3);

    // R3: rising pwm, lgate comparator later
    pwm = 1; step(1);
    chk(ls_on == 0 && hs_on == 0, "R3 ls drops first", {hs_on, ls_on}, 0);
    step(6);
    chk(hs_on == 0, "R3 hs waits for lgate", hs_on, 0);
    lgate_low = 1; step(2);
    chk(hs_on == 0, "R3 hs waits for sync", hs_on, 0);
    step(1);
    chk(hs_on == 1, "R3 hs on third edge", hs_on, 1);
    step(4);

    // R4: watchdog with phase never falling
    pwm = 0; lgate_low = 0;
    count_to_ls(k);
    chk(k == WD + 1, "R4 watchdog timeout steps", k, WD + 1);
    step(3);

    // R7 + R5: retarget inside wait, then fresh timeout
    pwm = 1; step(1);
    lgate_low = 1; step(4);
    chk(hs_on == 1, "R3 back to high", hs_on, 1);
    lgate_low = 0;
    pwm = 0; step(10);
    pwm = 1; step(20);
    chk(hs_on == 0 && ls_on == 0, "R7 rise during node wait still waits for gate", {hs_on, ls_on}, 0);
    pwm = 0;
    count_to_ls(k);
    chk(k == WD + 1, "R5 timeout restarts after retarget", k, WD + 1);
    chk(hs_on == 0, "R7 no high side across retarget", hs_on, 0);

    // R6: run drop
    pwm = 1; lgate_low = 1; step(6);
    run = 0; step(1);
    chk(hs_on == 0 && ls_on == 0, "R6 run drop clears gates", {hs_on, ls_on}, 0);
    for (int i = 0; i < 8; i++) begin
      pwm = ~pwm; phase_low = ~phase_low; step(1);
      chk(hs_on == 0 && ls_on == 0, "R6 held off while run low", {hs_on, ls_on}, 0);
    end
    phase_low = 0; pwm = 0; run = 1;
    step(2);
    chk(hs_on == 0 && ls_on == 0, "R6 restart through wait", {hs_on, ls_on}, 0);
    count_to_ls(k);
    chk(ls_on == 1, "R6 restart reaches low side", ls_on, 1);

    // Random stretch, compared cycle by cycle against the model (R10)
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom % 16;
      if (r == 0) pwm = ~pwm;
      if (r == 1 || r == 2) phase_low = ~phase_low;
      if (r == 3 || r == 4) lgate_low = ~lgate_low;
      if (r == 5 && ($urandom % 8) == 0) run = ~run;
      if (!run && ($urandom % 4) == 0) run = 1;
      step(1);
    end
    step(4);
    finish_up();
  end
endmodule